// File: doc/BRIEF.md
# Asynchronous CPU Bus Memory Emulator

This block lets synchronous on-chip logic stand in for a byte-wide static memory on the bus of an external 8-bit processor that runs near 1.3 MHz. The processor's address, chip enable, read/write strobe, output-disable line and write data arrive with no relation to the local clock. Each one passes through a two-flop synchroniser before it reaches the decode logic.

The upper address bits are compared against a window select supplied by local software. On a match, the rest of the upper byte picks one of sixteen 256-byte pages in a 4 KiB on-chip buffer, and the low byte picks the byte within that page. The data-bus output enable depends only on the decoded select and the processor's output-disable line, not on read/write. Because output-disable rises before a write strobe falls, the block has released the bus before the processor drives its write data.

One byte of the window is a command mailbox. A command written there is handed to a local command engine, and reads of that byte then return a fixed busy code. When the engine reports completion, reads return the engine's result code. A command written while one is still pending is dropped and sets a sticky overflow flag.

Top module: `busmem_emu`

## Requirements
- R1: After reset, data_oe_o, busy_o, ovf_o and cmd_valid_o are all 0.
- R2: A bus address selects the buffer when its bits [15:12] equal win_i. In that case bits [11:8] give the page and bits [7:0] give the byte, so the buffer index is address[11:0].
- R3: data_oe_o is 1 only when ce_n_i is 0, od_i is 0 and the address selects the buffer. It follows the bus pins with a latency of three clock cycles, whatever the state of rw_i.
- R4: While a selected address is held for a read, data_o carries the stored byte at that index.
- R5: A write is taken only when rw_i falls from 1 (read) to 0 (write) while ce_n_i is 0 and the address is unchanged since the previous synchronised sample. The byte stored is the write data seen in that first synchronised cycle. A write whose address changes together with the strobe is dropped.
- R6: Writes to an address outside the window, or made while ce_n_i is 1, leave the buffer unchanged.
- R7: Index 0xFFF is the command mailbox. A write to it while idle produces a one-cycle pulse on cmd_valid_o with the byte on cmd_o and sets busy_o. While busy_o is 1, reads of the mailbox return 0xB5.
- R8: A one-cycle pulse on done_i clears busy_o and loads result_i. From then on, reads of the mailbox return that result code. The result code is 0x00 after reset.
- R9: A mailbox write made while busy_o is 1 produces no cmd_valid_o pulse and leaves the pending command in place. It sets ovf_o, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| win_i | input | 4 | Window select compared with address bits [15:12] |
| addr_i | input | 16 | Processor address bus |
| data_i | input | 8 | Processor write data |
| ce_n_i | input | 1 | Processor chip enable, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| od_i | input | 1 | Processor output disable, high forbids driving the bus |
| data_o | output | 8 | Read data toward the bus pins |
| data_oe_o | output | 1 | Drive enable for the bus pins |
| cmd_valid_o | output | 1 | One-cycle pulse when a command is accepted |
| cmd_o | output | 8 | Accepted command byte |
| done_i | input | 1 | Command engine completion pulse |
| result_i | input | 8 | Result code sampled with done_i |
| busy_o | output | 1 | A command is pending |
| ovf_o | output | 1 | Sticky: a command arrived while busy |

## Verification
The properties assume that od_i and ce_n_i are held high through reset. They also assume that done_i is never pulsed in the same cycle as a mailbox write reaches the synchronised strobe. The stimulus meets both conditions: the bench keeps od_i and ce_n_i high until after reset, and pulses completion only once a bus cycle has ended. The write sequence raises od_i, settles address and data for several clocks, and only then lowers rw_i. This gives the synchronisers stable values to sample, as the write capture expects. A single deliberate case moves the address together with the strobe to exercise rejection.

// File: rtl/busmem_emu.sv
module busmem_emu #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int PAGE_W    = 4,
  parameter int LO_W      = 8,
  parameter int CMD_OFS   = 4095,
  parameter logic [7:0] BUSY_CODE = 8'hB5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-PAGE_W-LO_W-1:0]     win_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [DW-1:0]                 data_i,
  input  logic                          ce_n_i,
  input  logic                          rw_i,
  input  logic                          od_i,
  output logic [DW-1:0]                 data_o,
  output logic                          data_oe_o,
  output logic                          cmd_valid_o,
  output logic [DW-1:0]                 cmd_o,
  input  logic                          done_i,
  input  logic [DW-1:0]                 result_i,
  output logic                          busy_o,
  output logic                          ovf_o
);
  localparam int IDX_W = PAGE_W + LO_W;
  localparam int WIN_W = AW - IDX_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [AW-1:0] a_m, a_s, a_q;
  logic [DW-1:0] d_m, d_s;
  logic ce_m, ce_s, rw_m, rw_s, rw_q, od_m, od_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_m <= '0; a_s <= '0; a_q <= '0;
      d_m <= '0; d_s <= '0;
      ce_m <= 1'b1; ce_s <= 1'b1;
      rw_m <= 1'b1; rw_s <= 1'b1; rw_q <= 1'b1;
      od_m <= 1'b1; od_s <= 1'b1;
    end else begin
      a_m <= addr_i; a_s <= a_m; a_q <= a_s;
      d_m <= data_i; d_s <= d_m;
      ce_m <= ce_n_i; ce_s <= ce_m;
      rw_m <= rw_i; rw_s <= rw_m; rw_q <= rw_s;
      od_m <= od_i; od_s <= od_m;
    end
  end

  wire [IDX_W-1:0] idx    = a_s[IDX_W-1:0];
  wire             hit    = !ce_s && (a_s[AW-1 -: WIN_W] == win_i);
  wire             is_cmd = (idx == IDX_W'(CMD_OFS));
  wire             wr_stb = hit && rw_q && !rw_s && (a_s == a_q);
  wire             cmd_wr = wr_stb && is_cmd;
  wire             accept = cmd_wr && !busy_o && !done_i;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q, mbx_q, res_q;
  logic          cmd_rd_q;

  always_ff @(posedge clk) begin
    if (wr_stb && !is_cmd) mem[idx] <= d_s;
    mem_q <= mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_oe_o   <= 1'b0;
      cmd_rd_q    <= 1'b0;
      mbx_q       <= '0;
      res_q       <= '0;
      busy_o      <= 1'b0;
      ovf_o       <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_o       <= '0;
    end else begin
      data_oe_o   <= hit && !od_s;
      cmd_rd_q    <= is_cmd;
      mbx_q       <= busy_o ? BUSY_CODE : res_q;
      cmd_valid_o <= accept;
      if (accept) cmd_o <= d_s;
      if (done_i) begin
        busy_o <= 1'b0;
        res_q  <= result_i;
      end else if (accept) begin
        busy_o <= 1'b1;
      end
      if (cmd_wr && !accept) ovf_o <= 1'b1;
    end
  end

  assign data_o = cmd_rd_q ? mbx_q : mem_q;
endmodule

module busmem_emu_chk #(
  parameter int DW = 8,
  parameter logic [7:0] BUSY_CODE = 8'hB5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          od_i,
  input logic          ce_n_i,
  input logic          data_oe_o,
  input logic [DW-1:0] data_o,
  input logic          busy_o,
  input logic          ovf_o,
  input logic          cmd_valid_o,
  input logic          done_i,
  input logic [DW-1:0] result_i,
  input logic [DW-1:0] res_q,
  input logic          cmd_rd_q
);
  a_r3_oe_needs_od: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> !$past(od_i, 3));
  a_r3_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> !$past(ce_n_i, 3));
  a_r7_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd_q && $past(busy_o)) |-> data_o == BUSY_CODE);
  a_r7_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> busy_o && !$past(busy_o));
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !busy_o && res_q == $past(result_i));
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
endmodule

bind busmem_emu busmem_emu_chk #(.DW(DW), .BUSY_CODE(BUSY_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .od_i(od_i), .ce_n_i(ce_n_i),
  .data_oe_o(data_oe_o), .data_o(data_o), .busy_o(busy_o), .ovf_o(ovf_o),
  .cmd_valid_o(cmd_valid_o), .done_i(done_i), .result_i(result_i),
  .res_q(res_q), .cmd_rd_q(cmd_rd_q)
);

// File: tb/busmem_emu_tb.sv
module busmem_emu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  win_i = 4'hA;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic ce_n_i = 1'b1, rw_i = 1'b1, od_i = 1'b1;
  logic [7:0]  data_o, cmd_o, result_i = '0;
  logic data_oe_o, cmd_valid_o, busy_o, ovf_o, done_i = 1'b0;

  int checks = 0, errors = 0, pulses = 0;
  logic [7:0] last_cmd = '0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  busmem_emu dut_i (
    .clk(clk), .rst_n(rst_n), .win_i(win_i), .addr_i(addr_i), .data_i(data_i),
    .ce_n_i(ce_n_i), .rw_i(rw_i), .od_i(od_i), .data_o(data_o),
    .data_oe_o(data_oe_o), .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o),
    .done_i(done_i), .result_i(result_i), .busy_o(busy_o), .ovf_o(ovf_o)
  );

  always @(negedge clk) if (cmd_valid_o) begin
    pulses++;
    last_cmd = cmd_o;
  end

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7) + ((i >> 8) * 13) + 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d, bit ce = 1, bit move = 0);
    @(negedge clk);
    addr_i = a; ce_n_i = !ce; od_i = 1'b1; rw_i = 1'b1;
    repeat (3) @(negedge clk);
    data_i = d;
    @(negedge clk);
    rw_i = 1'b0;
    if (move) addr_i = a ^ 16'h0001;
    repeat (4) @(negedge clk);
    rw_i = 1'b1; ce_n_i = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cpu_read(logic [15:0] a, output logic [7:0] d, output logic oe, input bit od = 0);
    @(negedge clk);
    addr_i = a; ce_n_i = 1'b0; rw_i = 1'b1; od_i = od;
    repeat (5) @(negedge clk);
    d = data_o; oe = data_oe_o;
    ce_n_i = 1'b1; od_i = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (4) @(negedge clk);
    chk("R1 oe", data_oe_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 cmd_valid", cmd_valid_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 oe after release", data_oe_o, 0);

    // R2 R5: fill whole buffer except mailbox
    for (int i = 0; i < 4095; i++) cpu_write({4'hA, 12'(i)}, pat(i));
    // R2 R4 R3: read back whole buffer
    for (int i = 0; i < 4095; i++) begin
      cpu_read({4'hA, 12'(i)}, d, oe);
      chk("R4 read data", d, pat(i));
      chk("R3 oe on hit", oe, 1);
    end

    // R3: output enable gating
    cpu_read(16'hA010, d, oe, 1);
    chk("R3 od high blocks oe", oe, 0);
    cpu_read(16'h3010, d, oe);
    chk("R3 window miss no oe", oe, 0);
    @(negedge clk); addr_i = 16'hA010; ce_n_i = 1'b1; od_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 ce high no oe", data_oe_o, 0);
    od_i = 1'b1;
    @(negedge clk); addr_i = 16'hA011; ce_n_i = 1'b0; od_i = 1'b0; rw_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 oe independent of rw", data_oe_o, 1);
    rw_i = 1'b1; ce_n_i = 1'b1; od_i = 1'b1;
    repeat (3) @(negedge clk);

    // R6: ignored writes
    cpu_write(16'h3020, 8'h5A);
    cpu_read(16'hA020, d, oe);
    chk("R6 out-of-window write ignored", d, pat(12'h020));
    cpu_write(16'hA021, 8'h5A, 0);
    cpu_read(16'hA021, d, oe);
    chk("R6 ce-high write ignored", d, pat(12'h021));
    // R5: address moving with the strobe
    cpu_write(16'hA030, 8'hC3, 1, 1);
    cpu_read(16'hA030, d, oe);
    chk("R5 moving addr blocked a", d, pat(12'h030));
    cpu_read(16'hA031, d, oe);
    chk("R5 moving addr blocked b", d, pat(12'h031));

    // R8: result code zero after reset
    cpu_read(16'hAFFF, d, oe);
    chk("R8 reset result", d, 8'h00);

    // R7: command accepted
    cpu_write(16'hAFFF, 8'h42);
    chk("R7 one pulse", pulses, 1);
    chk("R7 cmd byte", last_cmd, 8'h42);
    chk("R7 busy set", busy_o, 1);
    cpu_read(16'hAFFF, d, oe);
    chk("R7 busy code", d, 8'hB5);

    // R9: command while busy
    cpu_write(16'hAFFF, 8'h99);
    chk("R9 no pulse", pulses, 1);
    chk("R9 ovf set", ovf_o, 1);
    chk("R9 cmd kept", cmd_o, 8'h42);

    // R8: completion
    @(negedge clk); done_i = 1'b1; result_i = 8'h3C;
    @(negedge clk); done_i = 1'b0; result_i = 8'h00;
    @(negedge clk);
    chk("R8 busy cleared", busy_o, 0);
    cpu_read(16'hAFFF, d, oe);
    chk("R8 result code", d, 8'h3C);
    chk("R9 ovf sticky", ovf_o, 1);

    cpu_write(16'hAFFF, 8'h17);
    chk("R7 second pulse", pulses, 2);
    chk("R7 second cmd", last_cmd, 8'h17);
    cpu_read(16'hA123, d, oe);
    chk("R4 buffer intact", d, pat(12'h123));

    done_flag = 1;
    summary();
  end
endmodule